// File: doc/BRIEF.md
# Clock power-down output gating controller

This block sits between the free-running clocks of a clock generator and its output pins. When an asynchronous power-down request arrives, it parks every output on a clean edge. It then raises a flag telling the rest of the chip that the oscillator and VCO may be turned off. When the request is withdrawn, every output resumes on its own source edge, and no pulse is clipped.

All logic runs on one fast sampling clock, `clk_i`. Every output clock, and the CPU-rate qualification clock, arrive as oversampled data levels. Each gated output is therefore a registered copy of its source, one `clk_i` cycle late. A differential output is modelled as a true pin and a complement pin, each with its own output enable. An enable at 0 models a tri-stated pin.

The park state of each differential pair comes from its mode bit, written by a host interface outside this block. Each output also has an enable bit. Clearing that bit parks the output exactly as a power-down would.

Top module: `clk_park_ctrl`

## Requirements
- R1: While running, each single-ended output equals its source delayed by one `clk_i` cycle. Each differential true pin equals its source delayed by one cycle, its complement is the inverse, and both pin enables are 1.
- R2: The power-down input passes through `SYNC_STAGES` flops. It is qualified only when the synchronized level is high at `QUAL_EDGES` (default 2) consecutive sampled rising edges of `cpu_clk_i`. A pulse that spans fewer qualifying edges leaves every output as in R1.
- R3: After qualification, each enabled single-ended output stops at its source's next high-to-low transition. It then stays low while the request is held.
- R4: After qualification, each differential pair stops at the next low-to-high transition of its true source, which is the high-to-low transition of its complement. The true pin stays high across the stop. The complement enable falls to 0 with the complement at 0.
- R5: A parked pair whose mode bit is 0 drives its true pin high (`diff_t_oe_o`=1, `diff_t_o`=1) and floats its complement (`diff_c_oe_o`=0).
- R6: A parked pair whose mode bit is 1 has both pin enables at 0 while the request is held.
- R7: `off_ok_o` is high only while a qualified request is held and every output is parked. It rises one cycle after the last output parks, and it is low within `SYNC_STAGES`+3 cycles after the request falls.
- R8: A synchronized low level clears qualification at once, with no CPU edge needed. A pair floated under mode 1 drives its true pin high (`diff_t_oe_o`=1) within `SYNC_STAGES`+3 cycles of `pd_i` falling.
- R9: On release, a single-ended output resumes at its source's next low-to-high transition. A pair resumes at its true source's next high-to-low transition, with true 0, complement 1 and both enables 1. The spread between the first and the last output to resume is at most two periods of the slowest single-ended source.
- R10: No output ever shows a runt pulse. Every high and low level of a single-ended output lasts at least its source's half period, and a high level lasts exactly one half period. On a pair, the true pin's low levels and the complement's high levels last exactly one half period. The complement counts as low while floated.
- R11: An enable bit at 0 parks its own output on the same edge and in the same state that a power-down would use, with no power-down applied. The other outputs keep running. Setting the bit back to 1 restarts the output as in R9.
- R12: While `rst_ni` is low, every single-ended output is 0, every true pin is driven high, every complement is floated, and `off_ok_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock; also counts the restart window |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_i | input | 1 | Asynchronous active-high power-down request |
| cpu_clk_i | input | 1 | Oversampled CPU-rate complement clock used for qualification |
| se_clk_i | input | N_SE | Free-running single-ended source clocks |
| diff_clk_i | input | N_DIFF | Free-running differential sources (true phase) |
| se_en_i | input | N_SE | Per-output run enable, single-ended |
| diff_en_i | input | N_DIFF | Per-pair run enable, differential |
| diff_mode_i | input | N_DIFF | Park mode: 0 true high / complement floated, 1 both floated |
| se_o | output | N_SE | Gated single-ended outputs |
| diff_t_o | output | N_DIFF | Gated true pins |
| diff_c_o | output | N_DIFF | Gated complement pins |
| diff_t_oe_o | output | N_DIFF | True pin drive enable (0 = tri-state) |
| diff_c_oe_o | output | N_DIFF | Complement pin drive enable (0 = tri-state) |
| off_ok_o | output | 1 | All outputs parked under a qualified request; oscillator and VCO may stop |

## Verification
Some properties are checked by assertions on every cycle. A park may happen only on the matching source edge, and a resume only on the opposite edge. Qualification may appear only right after a sampled CPU edge, and it must drop once the synchronized request is low. The shutdown flag must imply parked outputs, and each parked pair must hold the state its mode bit selects. Other properties only the bench's scenarios can show: whole pulse widths across entry and exit, immunity to a short request, the spread of restart times across outputs, and the re-drive of floated pins after release. The bench shows these by sweeping all four mode combinations and by toggling the enables.

// File: rtl/clk_park_pkg.sv
package clk_park_pkg;

  typedef enum logic {
    GS_PARKED = 1'b0,
    GS_RUN    = 1'b1
  } gate_st_e;

  typedef struct packed {
    logic t;
    logic c;
    logic t_oe;
    logic c_oe;
  } diff_pin_t;

  // parked with true driven high, complement floated
  localparam diff_pin_t DIFF_IDLE = '{t: 1'b1, c: 1'b0, t_oe: 1'b1, c_oe: 1'b0};

endpackage

// File: rtl/clk_park_pd_qual.sv
module clk_park_pd_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_EDGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  input  logic cpu_clk_i,
  output logic stop_o
);

  localparam int CW = $clog2(QUAL_EDGES + 1);
  localparam logic [CW-1:0] HIT_MAX = CW'(QUAL_EDGES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   cpu_q, prime_q;
  logic [CW-1:0]          hits_q;
  logic                   pd_s, cpu_rise;

  assign pd_s     = sync_q[SYNC_STAGES-1];
  assign cpu_rise = prime_q & ~cpu_q & cpu_clk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      cpu_q   <= 1'b0;
      prime_q <= 1'b0;
      hits_q  <= '0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], pd_i};
      cpu_q   <= cpu_clk_i;
      prime_q <= 1'b1;
      // release is immediate; assertion waits for consecutive edges
      if (!pd_s)                            hits_q <= '0;
      else if (cpu_rise && hits_q != HIT_MAX) hits_q <= hits_q + CW'(1);
    end
  end

  assign stop_o = (hits_q == HIT_MAX);

  // R2
  stop_on_cpu_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_o) |-> $past(cpu_clk_i) && !$past(cpu_clk_i, 2));

  // R8
  release_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_s |=> !stop_o);

endmodule

// File: rtl/clk_park_se.sv
module clk_park_se
  import clk_park_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic stop_i,
  output logic out_o,
  output logic parked_o
);

  logic     src_q, prime_q, rise, fall;
  gate_st_e run_q, run_d;

  assign rise = prime_q & ~src_q & src_i;
  assign fall = prime_q & src_q & ~src_i;

  always_comb begin
    run_d = run_q;
    if (run_q == GS_RUN && stop_i && fall)           run_d = GS_PARKED;
    else if (run_q == GS_PARKED && !stop_i && rise)  run_d = GS_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= 1'b0;
      prime_q <= 1'b0;
      run_q   <= GS_PARKED;
      out_o   <= 1'b0;
    end else begin
      src_q   <= src_i;
      prime_q <= 1'b1;
      run_q   <= run_d;
      out_o   <= src_i & (run_d == GS_RUN);
    end
  end

  assign parked_o = (run_q == GS_PARKED);

  // R3
  se_park_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(parked_o) |-> !out_o && $past(out_o));

  // R9
  se_resume_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(parked_o) |-> out_o && !$past(out_o));

endmodule

// File: rtl/clk_park_diff.sv
module clk_park_diff
  import clk_park_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      src_i,
  input  logic      mode_i,
  input  logic      stop_i,
  output diff_pin_t pin_o,
  output logic      parked_o
);

  logic      src_q, prime_q, rise, fall;
  gate_st_e  run_q, run_d;
  diff_pin_t pin_d;

  // complement high-to-low == true low-to-high
  assign rise = prime_q & ~src_q & src_i;
  assign fall = prime_q & src_q & ~src_i;

  always_comb begin
    run_d = run_q;
    if (run_q == GS_RUN && stop_i && rise)          run_d = GS_PARKED;
    else if (run_q == GS_PARKED && !stop_i && fall) run_d = GS_RUN;
  end

  always_comb begin
    if (run_d == GS_RUN) begin
      pin_d = '{t: src_i, c: ~src_i, t_oe: 1'b1, c_oe: 1'b1};
    end else begin
      pin_d      = DIFF_IDLE;
      // mode 1 floats the true pin only while the request is held
      pin_d.t_oe = ~(mode_i & stop_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= 1'b0;
      prime_q <= 1'b0;
      run_q   <= GS_PARKED;
      pin_o   <= DIFF_IDLE;
    end else begin
      src_q   <= src_i;
      prime_q <= 1'b1;
      run_q   <= run_d;
      pin_o   <= pin_d;
    end
  end

  assign parked_o = (run_q == GS_PARKED);

  // R4
  diff_park_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(parked_o) |-> pin_o.t && !$past(pin_o.t) && !pin_o.c_oe);

  // R9
  diff_resume_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(parked_o) |-> !pin_o.t && pin_o.c && pin_o.c_oe && pin_o.t_oe);

  // R5
  diff_mode0_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parked_o && !$past(mode_i)) |-> pin_o.t_oe && pin_o.t && !pin_o.c_oe);

  // R6
  diff_mode1_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parked_o && $past(mode_i) && $past(stop_i)) |-> !pin_o.t_oe && !pin_o.c_oe);

endmodule

// File: rtl/clk_park_ctrl.sv
module clk_park_ctrl
  import clk_park_pkg::*;
#(
  parameter int N_SE        = 3,
  parameter int N_DIFF      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_EDGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_i,
  input  logic              cpu_clk_i,
  input  logic [N_SE-1:0]   se_clk_i,
  input  logic [N_DIFF-1:0] diff_clk_i,
  input  logic [N_SE-1:0]   se_en_i,
  input  logic [N_DIFF-1:0] diff_en_i,
  input  logic [N_DIFF-1:0] diff_mode_i,
  output logic [N_SE-1:0]   se_o,
  output logic [N_DIFF-1:0] diff_t_o,
  output logic [N_DIFF-1:0] diff_c_o,
  output logic [N_DIFF-1:0] diff_t_oe_o,
  output logic [N_DIFF-1:0] diff_c_oe_o,
  output logic              off_ok_o
);

  logic              stop;
  logic [N_SE-1:0]   se_parked;
  logic [N_DIFF-1:0] diff_parked;
  diff_pin_t         pins [N_DIFF];

  clk_park_pd_qual #(
    .SYNC_STAGES (SYNC_STAGES),
    .QUAL_EDGES  (QUAL_EDGES)
  ) pd_qual_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pd_i      (pd_i),
    .cpu_clk_i (cpu_clk_i),
    .stop_o    (stop)
  );

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    clk_park_se se_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (se_clk_i[i]),
      .stop_i   (stop | ~se_en_i[i]),
      .out_o    (se_o[i]),
      .parked_o (se_parked[i])
    );
  end

  for (genvar j = 0; j < N_DIFF; j++) begin : g_diff
    clk_park_diff diff_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (diff_clk_i[j]),
      .mode_i   (diff_mode_i[j]),
      .stop_i   (stop | ~diff_en_i[j]),
      .pin_o    (pins[j]),
      .parked_o (diff_parked[j])
    );
    assign diff_t_o[j]    = pins[j].t;
    assign diff_c_o[j]    = pins[j].c;
    assign diff_t_oe_o[j] = pins[j].t_oe;
    assign diff_c_oe_o[j] = pins[j].c_oe;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_ok_o <= 1'b0;
    else         off_ok_o <= stop & (&se_parked) & (&diff_parked);
  end

  // R7
  off_ok_parked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_ok_o |-> (se_o == '0) && (diff_c_oe_o == '0));

endmodule

// File: tb/clk_park_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_park_ctrl_tb_top;

  localparam int N_SE   = 2;
  localparam int N_DIFF = 2;
  localparam int SYNC   = 2;
  localparam int SKEW_MAX = 2 * 2 * 5;  // two periods of slowest SE source

  logic clk = 1'b0;
  logic rst_ni;
  logic pd;
  logic cpu_src;
  logic [N_SE-1:0]   se_src, se_prev, se_en;
  logic [N_DIFF-1:0] d_src, d_prev, d_en, d_mode;
  logic [N_SE-1:0]   se_o;
  logic [N_DIFF-1:0] diff_t_o, diff_c_o, diff_t_oe_o, diff_c_oe_o;
  logic off_ok_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_park_ctrl #(
    .N_SE        (N_SE),
    .N_DIFF      (N_DIFF),
    .SYNC_STAGES (SYNC),
    .QUAL_EDGES  (2)
  ) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .pd_i        (pd),
    .cpu_clk_i   (cpu_src),
    .se_clk_i    (se_src),
    .diff_clk_i  (d_src),
    .se_en_i     (se_en),
    .diff_en_i   (d_en),
    .diff_mode_i (d_mode),
    .se_o        (se_o),
    .diff_t_o    (diff_t_o),
    .diff_c_o    (diff_c_o),
    .diff_t_oe_o (diff_t_oe_o),
    .diff_c_oe_o (diff_c_oe_o),
    .off_ok_o    (off_ok_o)
  );

  function automatic int se_half(int i);
    return (i == 0) ? 3 : 5;
  endfunction

  function automatic int d_half(int j);
    return (j == 0) ? 2 : 3;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  // sources change 2 ns after each rising edge; *_prev is what the DUT last sampled
  int se_cnt [N_SE];
  int d_cnt [N_DIFF];
  int cpu_cnt;
  initial begin
    se_src = '0; d_src = '0; cpu_src = 1'b0; se_prev = '0; d_prev = '0;
    for (int i = 0; i < N_SE; i++) se_cnt[i] = i;
    for (int j = 0; j < N_DIFF; j++) d_cnt[j] = j;
    cpu_cnt = 1;
    forever begin
      @(posedge clk); #2;
      se_prev = se_src;
      d_prev  = d_src;
      for (int i = 0; i < N_SE; i++) begin
        if (se_cnt[i] + 1 >= se_half(i)) begin se_cnt[i] = 0; se_src[i] = ~se_src[i]; end
        else se_cnt[i]++;
      end
      for (int j = 0; j < N_DIFF; j++) begin
        if (d_cnt[j] + 1 >= d_half(j)) begin d_cnt[j] = 0; d_src[j] = ~d_src[j]; end
        else d_cnt[j]++;
      end
      if (cpu_cnt + 1 >= 2) begin cpu_cnt = 0; cpu_src = ~cpu_src; end
      else cpu_cnt++;
    end
  end

  // pulse-width and shutdown-flag monitor
  int   se_len [N_SE];
  logic se_lvl [N_SE];
  bit   se_seen [N_SE];
  int   t_len [N_DIFF];
  logic t_lvl [N_DIFF];
  bit   t_seen [N_DIFF];
  int   c_len [N_DIFF];
  logic c_lvl [N_DIFF];
  bit   c_seen [N_DIFF];
  initial begin
    wait (rst_ni === 1'b1);
    @(negedge clk);
    for (int i = 0; i < N_SE; i++) begin se_lvl[i] = se_o[i]; se_len[i] = 0; se_seen[i] = 0; end
    for (int j = 0; j < N_DIFF; j++) begin
      t_lvl[j] = diff_t_o[j]; t_len[j] = 0; t_seen[j] = 0;
      c_lvl[j] = diff_c_o[j] & diff_c_oe_o[j]; c_len[j] = 0; c_seen[j] = 0;
    end
    forever begin
      @(negedge clk);
      if (off_ok_o)  // R7
        chk(se_o == '0 && diff_c_oe_o == '0, "R7", "off_ok with output live",
            int'({se_o, diff_c_oe_o}), 0);
      for (int i = 0; i < N_SE; i++) begin
        if (se_o[i] == se_lvl[i]) se_len[i]++;
        else begin
          if (se_seen[i]) begin  // R10
            if (se_lvl[i]) chk(se_len[i] == se_half(i), "R10", "se high width", se_len[i], se_half(i));
            else           chk(se_len[i] >= se_half(i), "R10", "se low width", se_len[i], se_half(i));
          end
          se_seen[i] = 1; se_lvl[i] = se_o[i]; se_len[i] = 1;
        end
      end
      for (int j = 0; j < N_DIFF; j++) begin
        if (diff_t_o[j] == t_lvl[j]) t_len[j]++;
        else begin
          if (t_seen[j]) begin  // R10
            if (t_lvl[j]) chk(t_len[j] >= d_half(j), "R10", "true high width", t_len[j], d_half(j));
            else          chk(t_len[j] == d_half(j), "R10", "true low width", t_len[j], d_half(j));
          end
          t_seen[j] = 1; t_lvl[j] = diff_t_o[j]; t_len[j] = 1;
        end
        if ((diff_c_o[j] & diff_c_oe_o[j]) == c_lvl[j]) c_len[j]++;
        else begin
          if (c_seen[j]) begin  // R10
            if (c_lvl[j]) chk(c_len[j] == d_half(j), "R10", "comp high width", c_len[j], d_half(j));
            else          chk(c_len[j] >= d_half(j), "R10", "comp low width", c_len[j], d_half(j));
          end
          c_seen[j] = 1; c_lvl[j] = diff_c_o[j] & diff_c_oe_o[j]; c_len[j] = 1;
        end
      end
    end
  end

  task automatic check_follow(input string req, input int n);
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < N_SE; i++)
        chk(se_o[i] == se_prev[i], req, "se follows source", int'(se_o[i]), int'(se_prev[i]));
      for (int j = 0; j < N_DIFF; j++)
        chk(diff_t_o[j] == d_prev[j] && diff_c_o[j] == ~d_prev[j] &&
            diff_t_oe_o[j] && diff_c_oe_o[j], req, "pair follows source",
            int'({diff_t_o[j], diff_c_o[j], diff_t_oe_o[j], diff_c_oe_o[j]}),
            int'({d_prev[j], ~d_prev[j], 2'b11}));
    end
  endtask

  initial begin
    int fs [N_SE];
    int fd [N_DIFF];
    logic [N_SE-1:0]   lse;
    logic [N_DIFF-1:0] lce;
    int lo, hi;
    bit found;
    rst_ni = 1'b0; pd = 1'b0; se_en = '1; d_en = '1; d_mode = '0;
    repeat (6) @(negedge clk);
    // R12
    chk(se_o == '0 && off_ok_o == 1'b0, "R12", "reset se/off_ok", int'({se_o, off_ok_o}), 0);
    chk(diff_t_oe_o == '1 && diff_t_o == '1 && diff_c_oe_o == '0, "R12", "reset pair state",
        int'({diff_t_oe_o, diff_t_o, diff_c_oe_o}), int'({2'b11, 2'b11, 2'b00}));
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (40) @(negedge clk);
    check_follow("R1", 30);

    // R2: short request, at most one sampled CPU edge
    pd = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    pd = 1'b0;
    check_follow("R2", 30);

    for (int m = 0; m < 4; m++) begin
      d_mode = m[1:0];
      @(negedge clk);
      pd = 1'b1;
      for (int k = 0; k < 80 && !off_ok_o; k++) @(negedge clk);
      chk(off_ok_o, "R7", "off_ok raised after parking", int'(off_ok_o), 1);
      repeat (20) begin
        @(negedge clk);
        chk(se_o == '0, "R3", "se held low", int'(se_o), 0);
        for (int j = 0; j < N_DIFF; j++) begin
          chk(!diff_c_oe_o[j], "R4", "complement floated", int'(diff_c_oe_o[j]), 0);
          if (!d_mode[j])
            chk(diff_t_oe_o[j] && diff_t_o[j], "R5", "true driven high",
                int'({diff_t_oe_o[j], diff_t_o[j]}), 3);
          else
            chk(!diff_t_oe_o[j], "R6", "true floated", int'(diff_t_oe_o[j]), 0);
        end
      end
      // release and measure restart spread
      pd = 1'b0;
      lse = se_o; lce = diff_c_oe_o;
      for (int i = 0; i < N_SE; i++) fs[i] = -1;
      for (int j = 0; j < N_DIFF; j++) fd[j] = -1;
      for (int c = 1; c <= 40; c++) begin
        @(negedge clk);
        if (c == SYNC + 3) begin
          chk(diff_t_oe_o == '1, "R8", "true re-driven after release", int'(diff_t_oe_o), 3);
          chk(!off_ok_o, "R7", "off_ok dropped after release", int'(off_ok_o), 0);
        end
        for (int i = 0; i < N_SE; i++) if (se_o[i] && !lse[i] && fs[i] < 0) fs[i] = c;
        for (int j = 0; j < N_DIFF; j++) if (diff_c_oe_o[j] && !lce[j] && fd[j] < 0) fd[j] = c;
        lse = se_o; lce = diff_c_oe_o;
      end
      lo = 1000; hi = -1; found = 1;
      for (int i = 0; i < N_SE; i++) begin
        if (fs[i] < 0) found = 0;
        if (fs[i] < lo) lo = fs[i];
        if (fs[i] > hi) hi = fs[i];
      end
      for (int j = 0; j < N_DIFF; j++) begin
        if (fd[j] < 0) found = 0;
        if (fd[j] < lo) lo = fd[j];
        if (fd[j] > hi) hi = fd[j];
      end
      chk(found && (hi - lo) <= SKEW_MAX, "R9", "restart spread", hi - lo, SKEW_MAX);
      check_follow("R9", 10);
    end

    // R11: per-output enables, no power-down
    d_mode = 2'b10;
    se_en = 2'b10; d_en = 2'b01;
    repeat (20) @(negedge clk);
    repeat (15) begin
      @(negedge clk);
      chk(se_o[0] == 1'b0, "R11", "disabled se low", int'(se_o[0]), 0);
      chk(se_o[1] == se_prev[1], "R11", "enabled se runs", int'(se_o[1]), int'(se_prev[1]));
      chk(!diff_t_oe_o[1] && !diff_c_oe_o[1], "R11", "disabled pair floated",
          int'({diff_t_oe_o[1], diff_c_oe_o[1]}), 0);
      chk(diff_t_o[0] == d_prev[0] && diff_c_oe_o[0], "R11", "enabled pair runs",
          int'(diff_t_o[0]), int'(d_prev[0]));
      chk(!off_ok_o, "R11", "no off_ok without request", int'(off_ok_o), 0);
    end
    se_en = '1; d_en = '1;
    repeat (20) @(negedge clk);
    check_follow("R11", 15);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule